// File: doc/BRIEF.md
# Dual-Mode Issue Scheduler

This block is the issue stage of a core that can run in two ways. In out-of-order mode it keeps one shared pool of waiting instructions from up to two threads. Any instruction whose operands are available may be picked, and a broadcast result tag marks every waiting consumer of that tag ready. In in-order multithreaded mode the same entry array is cut into eight equal partitions, one for each thread. Each partition behaves as a FIFO, and only the oldest instruction of each thread is a candidate for issue.

Each cycle one instruction can be inserted, with its thread number, two source tags with their ready flags, and a destination tag. One result tag can be broadcast. Up to four grants go out through packed issue slots. An issued entry leaves the array at the clock edge that ends its grant cycle. The surviving entries are compacted toward the low end of the pool, or of their partition, so that a lower index always means an older entry. The mode is requested by an input and changes only once the array drains.

Top module: `dms_sched`

## Requirements
- R1: After reset the array is empty, the mode is out-of-order (mode_o = 0), no issue slot is valid, and the round-robin start thread is 0.
- R2: In out-of-order mode (mode_o = 0) any ready entry may issue regardless of older unready entries. When more than four are ready, the four oldest are granted, oldest in slot 0. Valid slots are always packed from slot 0 upward.
- R3: A valid broadcast whose tag equals a stored source tag sets that source ready, and the entry becomes eligible in the following cycle. An insert whose source tag equals the broadcast tag in the same cycle is stored as ready.
- R4: In out-of-order mode only thread numbers 0 and 1 are accepted, and the shared pool holds all 16 entries. ins_ready_o is low for a higher thread number or when the pool is full.
- R5: In in-order mode (mode_o = 1) thread t owns entries 2t and 2t+1. ins_ready_o is low when the inserting thread's partition holds two entries, and other threads are unaffected.
- R6: In in-order mode only the head (oldest) entry of each thread may issue, so one thread's instructions leave in insertion order and at most one of them issues per cycle.
- R7: In in-order mode the eligible heads are scanned starting at a rotating thread number. After any grant, the start moves to one past the last thread granted.
- R8: When mode_req_i differs from mode_o, inserts are refused. The mode takes the requested value at the first edge where no entry remains after that cycle's grants.
- R9: A granted entry is removed at the end of its grant cycle and is never issued twice.
- R10: An insert offered while ins_ready_o is low leaves no trace in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 1 | Requested mode: 0 out-of-order, 1 in-order multithreaded |
| mode_o | output | 1 | Current mode |
| ins_valid_i | input | 1 | Insert request |
| ins_ready_o | output | 1 | Insert accepted this cycle |
| ins_tid_i | input | 3 | Thread number of the insert |
| ins_src0_i | input | 6 | First source tag |
| ins_src0_rdy_i | input | 1 | First source already available |
| ins_src1_i | input | 6 | Second source tag |
| ins_src1_rdy_i | input | 1 | Second source already available |
| ins_dst_i | input | 6 | Destination tag |
| wb_valid_i | input | 1 | Result broadcast valid |
| wb_tag_i | input | 6 | Broadcast result tag |
| iss_valid_o | output | 4 | Issue slot valid, packed from slot 0 |
| iss_tid_o | output | 4x3 | Thread number per issue slot |
| iss_dst_o | output | 4x6 | Destination tag per issue slot |

## Verification
The bench builds a few small sets of entries. One set has more ready entries than issue slots, which shows whether grants follow age and stay packed. One set has a blocked older entry behind a ready younger one, which shows whether the pool bypasses the blocked entry while a partition does not. One set gives eight threads each a waiting head, all woken by a single tag, which shows the round-robin start and how it advances. Filling the pool and a partition, offering foreign thread numbers, and requesting a mode change with work still pending test whether refused inserts really leave the array untouched and whether the mode holds until the array drains.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam logic MODE_OOO = 1'b0;
  localparam logic MODE_INO = 1'b1;
endpackage

// File: rtl/dms_wakeup.sv
module dms_wakeup #(
  parameter int N_ENT = 16,
  parameter int TAG_W = 6
) (
  input  logic [N_ENT-1:0]            vld_i,
  input  logic [N_ENT-1:0][TAG_W-1:0] s0_i,
  input  logic [N_ENT-1:0]            s0r_i,
  input  logic [N_ENT-1:0][TAG_W-1:0] s1_i,
  input  logic [N_ENT-1:0]            s1r_i,
  input  logic                        wb_valid_i,
  input  logic [TAG_W-1:0]            wb_tag_i,
  output logic [N_ENT-1:0]            s0r_o,
  output logic [N_ENT-1:0]            s1r_o,
  output logic [N_ENT-1:0]            rdy_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign s0r_o[i] = s0r_i[i] | (wb_valid_i & (s0_i[i] == wb_tag_i));
    assign s1r_o[i] = s1r_i[i] | (wb_valid_i & (s1_i[i] == wb_tag_i));
    // eligibility uses registered bits: wakeup takes effect next cycle
    assign rdy_o[i] = vld_i[i] & s0r_i[i] & s1r_i[i];
  end
endmodule

// File: rtl/dms_select.sv
module dms_select #(
  parameter int N_ENT      = 16,
  parameter int TAG_W      = 6,
  parameter int ISSUE_W    = 4,
  parameter int IO_THREADS = 8,
  localparam int TID_W = $clog2(IO_THREADS),
  localparam int PART  = N_ENT / IO_THREADS,
  localparam int CW    = $clog2(ISSUE_W + 1),
  localparam int SW    = $clog2(ISSUE_W)
) (
  input  logic                          mode_i,
  input  logic [N_ENT-1:0]              rdy_i,
  input  logic [N_ENT-1:0][TID_W-1:0]   tid_i,
  input  logic [N_ENT-1:0][TAG_W-1:0]   dst_i,
  input  logic [TID_W-1:0]              rr_i,
  output logic [N_ENT-1:0]              grant_o,
  output logic [ISSUE_W-1:0]            iss_valid_o,
  output logic [ISSUE_W-1:0][TID_W-1:0] iss_tid_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst_o,
  output logic [TID_W-1:0]              rr_o
);
  import dms_pkg::*;
  localparam logic [CW-1:0] ISSUE_C = CW'(ISSUE_W);

  always_comb begin
    logic [CW-1:0] cnt;
    logic [TID_W-1:0] t;
    int h;
    cnt         = '0;
    grant_o     = '0;
    iss_valid_o = '0;
    iss_tid_o   = '0;
    iss_dst_o   = '0;
    rr_o        = rr_i;
    t           = '0;
    h           = 0;
    if (mode_i == MODE_OOO) begin
      // compacted array: low index = oldest
      for (int i = 0; i < N_ENT; i++) begin
        if (rdy_i[i] && cnt < ISSUE_C) begin
          grant_o[i]              = 1'b1;
          iss_valid_o[cnt[SW-1:0]] = 1'b1;
          iss_tid_o[cnt[SW-1:0]]   = tid_i[i];
          iss_dst_o[cnt[SW-1:0]]   = dst_i[i];
          cnt = cnt + CW'(1);
        end
      end
    end else begin
      for (int k = 0; k < IO_THREADS; k++) begin
        t = rr_i + TID_W'(k);
        h = int'(t) * PART;
        if (rdy_i[h] && cnt < ISSUE_C) begin
          grant_o[h]               = 1'b1;
          iss_valid_o[cnt[SW-1:0]] = 1'b1;
          iss_tid_o[cnt[SW-1:0]]   = t;
          iss_dst_o[cnt[SW-1:0]]   = dst_i[h];
          rr_o = t + TID_W'(1);
          cnt  = cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dms_compact.sv
module dms_compact #(
  parameter int N_ENT      = 16,
  parameter int TAG_W      = 6,
  parameter int IO_THREADS = 8,
  localparam int TID_W = $clog2(IO_THREADS),
  localparam int PART  = N_ENT / IO_THREADS
) (
  input  logic                        mode_i,
  input  logic [N_ENT-1:0]            vld_i,
  input  logic [N_ENT-1:0]            grant_i,
  input  logic [N_ENT-1:0][TID_W-1:0] tid_i,
  input  logic [N_ENT-1:0][TAG_W-1:0] s0_i,
  input  logic [N_ENT-1:0]            s0r_i,
  input  logic [N_ENT-1:0][TAG_W-1:0] s1_i,
  input  logic [N_ENT-1:0]            s1r_i,
  input  logic [N_ENT-1:0][TAG_W-1:0] dst_i,
  input  logic                        ins_fire_i,
  input  logic [TID_W-1:0]            ins_tid_i,
  input  logic [TAG_W-1:0]            ins_s0_i,
  input  logic                        ins_s0r_i,
  input  logic [TAG_W-1:0]            ins_s1_i,
  input  logic                        ins_s1r_i,
  input  logic [TAG_W-1:0]            ins_dst_i,
  output logic [N_ENT-1:0]            vld_o,
  output logic [N_ENT-1:0][TID_W-1:0] tid_o,
  output logic [N_ENT-1:0][TAG_W-1:0] s0_o,
  output logic [N_ENT-1:0]            s0r_o,
  output logic [N_ENT-1:0][TAG_W-1:0] s1_o,
  output logic [N_ENT-1:0]            s1r_o,
  output logic [N_ENT-1:0][TAG_W-1:0] dst_o
);
  import dms_pkg::*;

  always_comb begin
    int seg_cnt [IO_THREADS];
    int sg;
    int dest;
    vld_o = '0; tid_o = '0; s0_o = '0; s0r_o = '0;
    s1_o  = '0; s1r_o = '0; dst_o = '0;
    for (int s = 0; s < IO_THREADS; s++) seg_cnt[s] = 0;
    sg = 0;
    dest = 0;
    // survivors slide down within their segment, keeping age order
    for (int i = 0; i < N_ENT; i++) begin
      if (vld_i[i] && !grant_i[i]) begin
        sg   = (mode_i == MODE_INO) ? (i / PART) : 0;
        dest = sg * PART + seg_cnt[sg];
        seg_cnt[sg] = seg_cnt[sg] + 1;
        vld_o[dest] = 1'b1;
        tid_o[dest] = tid_i[i];
        s0_o[dest]  = s0_i[i];
        s0r_o[dest] = s0r_i[i];
        s1_o[dest]  = s1_i[i];
        s1r_o[dest] = s1r_i[i];
        dst_o[dest] = dst_i[i];
      end
    end
    if (ins_fire_i) begin
      sg   = (mode_i == MODE_INO) ? int'(ins_tid_i) : 0;
      dest = sg * PART + seg_cnt[sg];
      if (dest < N_ENT) begin
        vld_o[dest] = 1'b1;
        tid_o[dest] = ins_tid_i;
        s0_o[dest]  = ins_s0_i;
        s0r_o[dest] = ins_s0r_i;
        s1_o[dest]  = ins_s1_i;
        s1r_o[dest] = ins_s1r_i;
        dst_o[dest] = ins_dst_i;
      end
    end
  end
endmodule

// File: rtl/dms_sched.sv
module dms_sched #(
  parameter int N_ENT       = 16,
  parameter int TAG_W       = 6,
  parameter int ISSUE_W     = 4,
  parameter int IO_THREADS  = 8,
  parameter int OOO_THREADS = 2,
  localparam int TID_W = $clog2(IO_THREADS),
  localparam int PART  = N_ENT / IO_THREADS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_req_i,
  output logic                          mode_o,
  input  logic                          ins_valid_i,
  output logic                          ins_ready_o,
  input  logic [TID_W-1:0]              ins_tid_i,
  input  logic [TAG_W-1:0]              ins_src0_i,
  input  logic                          ins_src0_rdy_i,
  input  logic [TAG_W-1:0]              ins_src1_i,
  input  logic                          ins_src1_rdy_i,
  input  logic [TAG_W-1:0]              ins_dst_i,
  input  logic                          wb_valid_i,
  input  logic [TAG_W-1:0]              wb_tag_i,
  output logic [ISSUE_W-1:0]            iss_valid_o,
  output logic [ISSUE_W-1:0][TID_W-1:0] iss_tid_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst_o
);
  import dms_pkg::*;

  logic                        mode_q, mode_d;
  logic [TID_W-1:0]            rr_q, rr_d;
  logic [N_ENT-1:0]            vld_q, vld_d;
  logic [N_ENT-1:0][TID_W-1:0] tid_q, tid_d;
  logic [N_ENT-1:0][TAG_W-1:0] s0_q, s0_d, s1_q, s1_d, dst_q, dst_d;
  logic [N_ENT-1:0]            s0r_q, s0r_d, s1r_q, s1r_d;
  logic [N_ENT-1:0]            s0r_w, s1r_w, rdy, grant;
  logic [IO_THREADS-1:0]       part_full;
  logic                        tgt_full, tid_ok, ins_fire, ins_s0r, ins_s1r;

  for (genvar p = 0; p < IO_THREADS; p++) begin : g_part
    assign part_full[p] = &vld_q[p*PART +: PART];
  end

  assign tgt_full    = (mode_q == MODE_INO) ? part_full[ins_tid_i] : (&vld_q);
  assign tid_ok      = (mode_q == MODE_INO) || (ins_tid_i < TID_W'(OOO_THREADS));
  assign ins_ready_o = (mode_req_i == mode_q) && !tgt_full && tid_ok;
  assign ins_fire    = ins_valid_i && ins_ready_o;
  assign ins_s0r     = ins_src0_rdy_i | (wb_valid_i & (ins_src0_i == wb_tag_i));
  assign ins_s1r     = ins_src1_rdy_i | (wb_valid_i & (ins_src1_i == wb_tag_i));
  assign mode_o      = mode_q;

  dms_wakeup #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_wake (
    .vld_i(vld_q), .s0_i(s0_q), .s0r_i(s0r_q), .s1_i(s1_q), .s1r_i(s1r_q),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i),
    .s0r_o(s0r_w), .s1r_o(s1r_w), .rdy_o(rdy)
  );

  dms_select #(.N_ENT(N_ENT), .TAG_W(TAG_W), .ISSUE_W(ISSUE_W),
               .IO_THREADS(IO_THREADS)) u_sel (
    .mode_i(mode_q), .rdy_i(rdy), .tid_i(tid_q), .dst_i(dst_q), .rr_i(rr_q),
    .grant_o(grant), .iss_valid_o(iss_valid_o), .iss_tid_o(iss_tid_o),
    .iss_dst_o(iss_dst_o), .rr_o(rr_d)
  );

  dms_compact #(.N_ENT(N_ENT), .TAG_W(TAG_W), .IO_THREADS(IO_THREADS)) u_cmp (
    .mode_i(mode_q), .vld_i(vld_q), .grant_i(grant), .tid_i(tid_q),
    .s0_i(s0_q), .s0r_i(s0r_w), .s1_i(s1_q), .s1r_i(s1r_w), .dst_i(dst_q),
    .ins_fire_i(ins_fire), .ins_tid_i(ins_tid_i),
    .ins_s0_i(ins_src0_i), .ins_s0r_i(ins_s0r),
    .ins_s1_i(ins_src1_i), .ins_s1r_i(ins_s1r), .ins_dst_i(ins_dst_i),
    .vld_o(vld_d), .tid_o(tid_d), .s0_o(s0_d), .s0r_o(s0r_d),
    .s1_o(s1_d), .s1r_o(s1r_d), .dst_o(dst_d)
  );

  // switch only when nothing survives this cycle's grants
  assign mode_d = ((mode_req_i != mode_q) && ((vld_q & ~grant) == '0)) ? mode_req_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OOO;
      rr_q   <= '0;
      vld_q  <= '0;
      tid_q  <= '0;
      s0_q   <= '0;
      s0r_q  <= '0;
      s1_q   <= '0;
      s1r_q  <= '0;
      dst_q  <= '0;
    end else begin
      mode_q <= mode_d;
      rr_q   <= rr_d;
      vld_q  <= vld_d;
      tid_q  <= tid_d;
      s0_q   <= s0_d;
      s0r_q  <= s0r_d;
      s1_q   <= s1_d;
      s1r_q  <= s1r_d;
      dst_q  <= dst_d;
    end
  end
endmodule

// File: rtl/dms_sched_chk.sv
module dms_sched_chk #(
  parameter int N_ENT       = 16,
  parameter int ISSUE_W     = 4,
  parameter int IO_THREADS  = 8,
  parameter int OOO_THREADS = 2,
  localparam int TID_W = $clog2(IO_THREADS),
  localparam int PART  = N_ENT / IO_THREADS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_req_i,
  input logic               mode_o,
  input logic [TID_W-1:0]   ins_tid_i,
  input logic               ins_ready_o,
  input logic [ISSUE_W-1:0] iss_valid_o,
  input logic [N_ENT-1:0]   vld_q,
  input logic [N_ENT-1:0]   grant
);
  function automatic logic [N_ENT-1:0] head_mask();
    logic [N_ENT-1:0] m;
    m = '0;
    for (int p = 0; p < IO_THREADS; p++) m[p*PART] = 1'b1;
    return m;
  endfunction
  localparam logic [N_ENT-1:0] HEADS = head_mask();

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q == '0) |-> (iss_valid_o == '0));

  p_pack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o & ISSUE_W'(iss_valid_o + ISSUE_W'(1))) == '0);

  p_tid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && (ins_tid_i >= TID_W'(OOO_THREADS))) |-> !ins_ready_o);

  p_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> ((grant & ~HEADS) == '0));

  p_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i != mode_o) |-> !ins_ready_o);

  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> ($past(vld_q & ~grant) == '0));
endmodule

bind dms_sched dms_sched_chk #(
  .N_ENT(N_ENT), .ISSUE_W(ISSUE_W), .IO_THREADS(IO_THREADS), .OOO_THREADS(OOO_THREADS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_req_i(mode_req_i), .mode_o(mode_o),
  .ins_tid_i(ins_tid_i), .ins_ready_o(ins_ready_o), .iss_valid_o(iss_valid_o),
  .vld_q(vld_q), .grant(grant)
);

// File: tb/tb_dms_sched.sv
module tb_dms_sched;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_req = 1'b0, mode;
  logic ins_valid = 1'b0, ins_ready;
  logic [2:0] ins_tid = '0;
  logic [5:0] s0 = '0, s1 = '0, dst = '0;
  logic s0r = 1'b1, s1r = 1'b1;
  logic wb_valid = 1'b0;
  logic [5:0] wb_tag = '0;
  logic [3:0] iss_valid;
  logic [3:0][2:0] iss_tid;
  logic [3:0][5:0] iss_dst;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dms_sched dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_req_i(mode_req), .mode_o(mode),
    .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_tid_i(ins_tid),
    .ins_src0_i(s0), .ins_src0_rdy_i(s0r), .ins_src1_i(s1), .ins_src1_rdy_i(s1r),
    .ins_dst_i(dst), .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
    .iss_valid_o(iss_valid), .iss_tid_o(iss_tid), .iss_dst_o(iss_dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ins(input int tid, input int tag0, input logic r0, input int d);
    ins_tid = 3'(tid); s0 = 6'(tag0); s0r = r0; s1 = '0; s1r = 1'b1; dst = 6'(d);
    ins_valid = 1'b1;
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic bcast(input int tag);
    wb_tag = 6'(tag); wb_valid = 1'b1;
    tick();
    wb_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mode", int'(mode), 0);
    chk("R1 issue", int'(iss_valid), 0);
    ins_tid = 3'd0; ins_valid = 1'b1; #1;
    chk("R1 ready", int'(ins_ready), 1);
    ins_valid = 1'b0;

    // R2/R3: six waiters on tag 5, woken together
    for (int i = 0; i < 6; i++) ins(i % 2, 5, 1'b0, 10 + i);
    chk("R3 no early issue", int'(iss_valid), 0);
    bcast(5);
    chk("R2 four granted", int'(iss_valid), 15);
    for (int k = 0; k < 4; k++) chk("R2 oldest order", int'(iss_dst[k]), 10 + k);
    chk("R2 slot tid", int'(iss_tid[1]), 1);
    tick();
    chk("R2 remainder packed", int'(iss_valid), 3);
    chk("R2 rem dst0", int'(iss_dst[0]), 14);
    chk("R2 rem dst1", int'(iss_dst[1]), 15);
    tick();
    chk("R9 freed", int'(iss_valid), 0);

    // R3 same-cycle capture
    wb_tag = 6'd7; wb_valid = 1'b1;
    ins(0, 7, 1'b0, 33);
    wb_valid = 1'b0;
    chk("R3 same cycle valid", int'(iss_valid), 1);
    chk("R3 same cycle dst", int'(iss_dst[0]), 33);
    tick();

    // R2 younger bypasses blocked older
    ins(0, 8, 1'b0, 48);
    ins(1, 0, 1'b1, 49);
    chk("R2 bypass valid", int'(iss_valid), 1);
    chk("R2 bypass dst", int'(iss_dst[0]), 49);
    tick();
    chk("R9 once", int'(iss_valid), 0);
    bcast(8);
    chk("R3 woken dst", int'(iss_dst[0]), 48);
    tick();

    // R4 thread number filter, R10 refused insert
    ins_tid = 3'd2; s0r = 1'b1; s1r = 1'b1; dst = 6'd63; ins_valid = 1'b1; #1;
    chk("R4 tid2 refused", int'(ins_ready), 0);
    tick();
    ins_valid = 1'b0;
    chk("R10 tid2 no trace", int'(iss_valid), 0);
    ins_tid = 3'd1; ins_valid = 1'b1; #1;
    chk("R4 tid1 accepted", int'(ins_ready), 1);
    ins_valid = 1'b0;

    // R4 pool capacity
    for (int i = 0; i < 16; i++) ins(i % 2, 50, 1'b0, i);
    ins_tid = 3'd0; s0r = 1'b1; dst = 6'd62; ins_valid = 1'b1; #1;
    chk("R4 pool full", int'(ins_ready), 0);
    tick();
    ins_valid = 1'b0;
    chk("R10 full no trace", int'(iss_valid), 0);
    bcast(50);
    for (int c = 0; c < 4; c++) begin
      chk("R2 drain valid", int'(iss_valid), 15);
      chk("R2 drain order", int'(iss_dst[0]), 4 * c);
      tick();
    end
    chk("R9 drained", int'(iss_valid), 0);

    // R8 mode change waits for drain
    ins(0, 60, 1'b0, 9);
    mode_req = 1'b1;
    ins_tid = 3'd0; ins_valid = 1'b1; #1;
    chk("R8 insert blocked", int'(ins_ready), 0);
    ins_valid = 1'b0;
    tick();
    chk("R8 held", int'(mode), 0);
    bcast(60);
    chk("R8 held while issuing", int'(mode), 0);
    chk("R8 last issue", int'(iss_valid), 1);
    tick();
    chk("R8 switched", int'(mode), 1);
    chk("R8 empty", int'(iss_valid), 0);

    // R5/R6 per-thread FIFO
    ins(0, 20, 1'b0, 40);
    ins(0, 0, 1'b1, 41);
    chk("R6 younger held", int'(iss_valid), 0);
    ins_tid = 3'd0; ins_valid = 1'b1; #1;
    chk("R5 partition full", int'(ins_ready), 0);
    ins_tid = 3'd1; #1;
    chk("R5 other thread free", int'(ins_ready), 1);
    ins_valid = 1'b0;
    bcast(20);
    chk("R6 head valid", int'(iss_valid), 1);
    chk("R6 head dst", int'(iss_dst[0]), 40);
    tick();
    chk("R6 next valid", int'(iss_valid), 1);
    chk("R6 next dst", int'(iss_dst[0]), 41);
    tick();
    chk("R9 io freed", int'(iss_valid), 0);

    // R7 round robin: start is thread 1 after thread 0 grants
    for (int t = 0; t < 8; t++) ins(t, 30, 1'b0, 50 + t);
    bcast(30);
    chk("R7 first valid", int'(iss_valid), 15);
    for (int k = 0; k < 4; k++) chk("R7 first tids", int'(iss_tid[k]), k + 1);
    chk("R7 first dst", int'(iss_dst[0]), 51);
    tick();
    chk("R7 second valid", int'(iss_valid), 15);
    for (int k = 0; k < 4; k++) chk("R7 second tids", int'(iss_tid[k]), (k + 5) % 8);
    tick();
    chk("R7 done", int'(iss_valid), 0);

    // R8 back to out-of-order when empty
    mode_req = 1'b0;
    tick();
    chk("R8 back", int'(mode), 0);

    finish_run();
  end
endmodule